// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream Walker

This block runs one transmit channel of a scatter-gather DMA. When it is started, it follows a chain of descriptors that sit in memory. It reads each descriptor through a narrow memory port that allows one request at a time. It streams the referenced buffer out as bytes, writes a completion status back into the descriptor, and moves to the next link. A packet may be spread across several descriptors. A start-of-packet flag in a descriptor sends that descriptor's five side-band words out on a separate word stream. An end-of-packet flag marks the final byte and raises a packet-done pulse.

The surrounding register block owns the run and idle bits and the current and tail pointers. The walker reads them when it starts. It reports back through single-cycle pulses: a new current pointer, halt, idle and packet done. Descriptors are 64 bytes apart in any layout the software picks. Each one is thirteen 32-bit little-endian words. Buffers must be word aligned. Only the low 32 bits of each 64-bit pointer field are used, and pointers are at most 32 bits wide.

Top module: `sgw_walker`

## Requirements
- R1: A walk begins only on a `start` pulse while `run` is 1 and `idle_in` is 0. In any other case no memory request is made and no pulse or stream output appears.
- R2: Descriptor word offsets from the descriptor address are fixed, in bytes. The next pointer is at +0, with its upper half at +4 ignored. The buffer address is at +8, with its upper half at +12 ignored. The control word is at +24 and the status word at +28. The side-band words are at +32 to +48. Bytes +16 to +23 are never used.
- R3: If a fetched status word has bit 31 set, `halt_set` pulses and the walk ends. That descriptor is not written, no bytes are streamed for it and `cur_we` does not pulse for it.
- R4: Control bits 22:0 give a byte count. That many bytes are read from the buffer and sent on the byte stream, lowest address first and least significant byte of each word first. A count of 0 sends nothing.
- R5: If control bit 27 is set, the five side-band words go out on the word stream in address order, with `app_last` on the fifth. If bit 27 is clear, no side-band word is sent.
- R6: If control bit 26 is set, `byte_last` marks the descriptor's final byte and `frame_done` pulses once after that byte. A zero-count descriptor with this flag pulses `frame_done` without sending a byte. If bit 26 is clear, there is no `byte_last` and no `frame_done`.
- R7: Each processed descriptor gets exactly one memory write. The write goes to its status word and carries the byte count OR 0x8000_0000. No other write is made.
- R8: After the write-back, `cur_we` pulses with `cur_out` equal to the descriptor's next pointer. If the finished descriptor's address equals `tail_ptr`, `idle_set` pulses and the walk ends. Otherwise the next descriptor is fetched. `halt_set` and `idle_set` never pulse together.
- R9: At most one memory request is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from request to `mem_ack`.
- R10: While a stream's valid is high and its ready is low, its data and last flag hold steady. No byte or word is lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Channel run enable |
| idle_in | input | 1 | Channel idle flag held by the register block |
| start | input | 1 | Single-cycle request to begin a walk |
| cur_ptr | input | ADDR_W | Address of the first descriptor to process |
| tail_ptr | input | ADDR_W | Address of the last descriptor to process |
| cur_out | output | ADDR_W | Updated current pointer |
| cur_we | output | 1 | Pulse: load `cur_out` into the current pointer |
| halt_set | output | 1 | Pulse: an already-completed descriptor was met |
| idle_set | output | 1 | Pulse: the tail descriptor was finished |
| frame_done | output | 1 | Pulse: an end-of-packet descriptor was finished |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of a 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request complete; `mem_rdata` valid in this cycle for reads |
| mem_rdata | input | 32 | Read data |
| byte_data | output | 8 | Payload byte |
| byte_valid | output | 1 | Payload byte valid |
| byte_last | output | 1 | Final byte of a packet |
| byte_ready | input | 1 | Payload sink ready |
| app_data | output | 32 | Side-band word |
| app_valid | output | 1 | Side-band word valid |
| app_last | output | 1 | Fifth side-band word |
| app_ready | input | 1 | Side-band sink ready |

## Verification
Single-descriptor packets are swept over every count from 0 to 9. This separates the full-word, partial-word and empty cases of the byte unpacking, including a zero-count end-of-packet descriptor. Every mix of counts from 0 to 4 across a three-descriptor packet shows whether bytes join cleanly across links. It also shows that only the final descriptor marks the end and only the first sends side-band words. Two back-to-back packets, a mid-chain completed descriptor, a completed first descriptor and a chain with neither flag set separate tail termination from halt termination. Backpressure and memory latency are varied across runs to show that stalls change timing only.

// File: rtl/sgw_pkg.sv
// Package: shared constants and state type for the descriptor walker.
// Assumes descriptors are arrays of little-endian 32-bit words.
package sgw_pkg;
    // Word indices inside one descriptor
    localparam int WD_NEXT   = 0;
    localparam int WD_BUF    = 2;
    localparam int WD_CTRL   = 6;
    localparam int WD_STAT   = 7;
    localparam int WD_APP    = 8;
    localparam int APP_WORDS = 5;
    localparam int WORD_B    = 4;

    // Control and status field positions
    localparam int LEN_W        = 23;
    localparam int CTL_SOP_BIT  = 27;
    localparam int CTL_EOP_BIT  = 26;
    localparam int STAT_CPL_BIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CTRL,
        ST_RD_NEXT,
        ST_RD_BUF,
        ST_APP_RD,
        ST_APP_PUSH,
        ST_DAT_RD,
        ST_DAT_PUSH,
        ST_DRAIN,
        ST_WB,
        ST_ADV
    } walk_st_t;
endpackage

// File: rtl/sgw_mem_port.sv
// Module: single-outstanding memory request register.
// Latches one command and holds it on the memory side until acknowledged.
// Assumes mem_ack is only raised while mem_req is high.
module sgw_mem_port #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    logic pending;

    // Capture a command when free; release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (cmd_valid && !pending) begin
            pending   <= 1'b1;
            mem_we    <= cmd_we;
            mem_addr  <= cmd_addr;
            mem_wdata <= cmd_wdata;
        end else if (pending && mem_ack) begin
            pending   <= 1'b0;
        end
    end

    // Memory-side and response-side views of the pending request.
    always_comb begin
        mem_req   = pending;
        cmd_ready = !pending;
        rsp_valid = pending && mem_ack;
        rsp_data  = mem_rdata;
    end

    // R9: request fields hold until the acknowledge
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: the sequencer never offers a command while one is outstanding
    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !pending);
endmodule

// File: rtl/sgw_byte_emit.sv
// Module: word-to-byte unpacker with valid/ready output.
// Takes one word with a byte count of 1..4 and sends the bytes least
// significant first. It flags the final byte when asked. Loads only when empty.
module sgw_byte_emit #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [2:0]        ld_cnt,
    input  logic              ld_last,
    output logic              empty,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] word_q;
    logic [2:0]        cnt_q;
    logic              last_q;

    // Load a fresh word, or shift one byte out per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            word_q <= ld_word;
            cnt_q  <= ld_cnt;
            last_q <= ld_last;
        end else if (out_valid && out_ready) begin
            word_q <= word_q >> 8;
            cnt_q  <= cnt_q - 3'd1;
        end
    end

    // Output view of the holding register.
    always_comb begin
        empty     = (cnt_q == 3'd0);
        out_valid = !empty;
        out_data  = word_q[7:0];
        out_last  = last_q && (cnt_q == 3'd1);
    end

    // R10: a stalled byte does not change
    p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R4: loads arrive only into an empty register with a legal count
    p_load_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (empty && ld_cnt != 3'd0 && int'(ld_cnt) <= NBYTES));
endmodule

// File: rtl/sgw_word_slot.sv
// Module: one-entry word register with valid/ready output for side-band words.
// Assumes load is only asserted while the slot is empty.
module sgw_word_slot #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              ld_last,
    output logic              empty,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);
    // Fill on load, drain on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_last  <= ld_last;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Empty flag for the sequencer.
    always_comb empty = !out_valid;

    // R10: a stalled side-band word does not change
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R5: no side-band word is overwritten before it is taken
    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/sgw_walker.sv
// Module: memory-to-stream scatter-gather descriptor walker, one channel.
// Fetches descriptors through a one-outstanding memory port and streams
// their buffers as bytes. Side-band words go out on packet start. Writes
// back status and advances until the tail is done or a completed
// descriptor is met.
// Assumes ADDR_W <= 32, word-aligned buffers and an external register
// block that applies the cur_we / halt_set / idle_set pulses.
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              idle_in,
    input  logic              start,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] tail_ptr,
    output logic [ADDR_W-1:0] cur_out,
    output logic              cur_we,
    output logic              halt_set,
    output logic              idle_set,
    output logic              frame_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [7:0]        byte_data,
    output logic              byte_valid,
    output logic              byte_last,
    input  logic              byte_ready,
    output logic [31:0]       app_data,
    output logic              app_valid,
    output logic              app_last,
    input  logic              app_ready
);
    localparam int APP_IDX_W = $clog2(APP_WORDS + 1);
    localparam logic [APP_IDX_W-1:0] APP_LAST_IDX = APP_IDX_W'(APP_WORDS - 1);

    walk_st_t              st;
    logic                  waiting;
    logic [ADDR_W-1:0]     dptr, nxt, baddr;
    logic [31:0]           ctl_word, hold;
    logic [LEN_W-1:0]      rem;
    logic [APP_IDX_W-1:0]  app_idx;

    logic                  cmd_valid, cmd_we, cmd_ready, rsp_valid;
    logic [ADDR_W-1:0]     cmd_addr;
    logic [31:0]           cmd_wdata, rsp_data;
    logic                  byte_load, byte_empty, byte_ld_last;
    logic [2:0]            byte_ld_cnt;
    logic                  app_load, app_empty;
    logic                  sop, eop, mem_state;
    logic [LEN_W-1:0]      blen;
    logic                  ctl_unused;

    // Address of a word inside a descriptor.
    function automatic logic [ADDR_W-1:0] wd_addr(input logic [ADDR_W-1:0] base, input int idx);
        return base + ADDR_W'(idx * WORD_B);
    endfunction

    // Decode the latched control word.
    always_comb begin
        sop        = ctl_word[CTL_SOP_BIT];
        eop        = ctl_word[CTL_EOP_BIT];
        blen       = ctl_word[LEN_W-1:0];
        ctl_unused = ^{ctl_word[31:28], ctl_word[25:LEN_W]};
    end

    // Build the memory command for the current state.
    always_comb begin
        mem_state = (st == ST_RD_STAT) || (st == ST_RD_CTRL) || (st == ST_RD_NEXT) ||
                    (st == ST_RD_BUF)  || (st == ST_APP_RD)  || (st == ST_WB) ||
                    ((st == ST_DAT_RD) && (rem != '0));
        cmd_valid = mem_state && !waiting;
        cmd_we    = 1'b0;
        cmd_wdata = '0;
        cmd_addr  = dptr;
        unique case (st)
            ST_RD_STAT: cmd_addr = wd_addr(dptr, WD_STAT);
            ST_RD_CTRL: cmd_addr = wd_addr(dptr, WD_CTRL);
            ST_RD_NEXT: cmd_addr = wd_addr(dptr, WD_NEXT);
            ST_RD_BUF:  cmd_addr = wd_addr(dptr, WD_BUF);
            ST_APP_RD:  cmd_addr = wd_addr(dptr, WD_APP + int'(app_idx));
            ST_DAT_RD:  cmd_addr = baddr;
            ST_WB: begin
                cmd_addr  = wd_addr(dptr, WD_STAT);
                cmd_we    = 1'b1;
                cmd_wdata = {1'b1, {(31 - LEN_W){1'b0}}, blen};
            end
            default:    cmd_addr = dptr;
        endcase
    end

    // Stream load strobes for payload and side-band words.
    always_comb begin
        byte_load    = (st == ST_DAT_PUSH) && byte_empty;
        byte_ld_cnt  = (rem >= LEN_W'(WORD_B)) ? 3'(WORD_B) : rem[2:0];
        byte_ld_last = eop && (rem <= LEN_W'(WORD_B));
        app_load     = (st == ST_APP_PUSH) && app_empty;
    end

    // Walk sequencer: fetch, stream, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            waiting    <= 1'b0;
            dptr       <= '0;
            nxt        <= '0;
            baddr      <= '0;
            ctl_word   <= '0;
            hold       <= '0;
            rem        <= '0;
            app_idx    <= '0;
            cur_out    <= '0;
            cur_we     <= 1'b0;
            halt_set   <= 1'b0;
            idle_set   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            cur_we     <= 1'b0;
            halt_set   <= 1'b0;
            idle_set   <= 1'b0;
            frame_done <= 1'b0;
            if (cmd_valid && cmd_ready) waiting <= 1'b1;
            if (rsp_valid)              waiting <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start && run && !idle_in) begin
                        dptr <= cur_ptr;
                        st   <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (rsp_valid) begin
                        if (rsp_data[STAT_CPL_BIT]) begin
                            halt_set <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            st <= ST_RD_CTRL;
                        end
                    end
                end
                ST_RD_CTRL: begin
                    if (rsp_valid) begin
                        ctl_word <= rsp_data;
                        st       <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: begin
                    if (rsp_valid) begin
                        nxt <= rsp_data[ADDR_W-1:0];
                        st  <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (rsp_valid) begin
                        baddr   <= rsp_data[ADDR_W-1:0];
                        rem     <= blen;
                        app_idx <= '0;
                        st      <= sop ? ST_APP_RD : ST_DAT_RD;
                    end
                end
                ST_APP_RD: begin
                    if (rsp_valid) begin
                        hold <= rsp_data;
                        st   <= ST_APP_PUSH;
                    end
                end
                ST_APP_PUSH: begin
                    if (app_load) begin
                        app_idx <= app_idx + 1'b1;
                        st      <= (app_idx == APP_LAST_IDX) ? ST_DAT_RD : ST_APP_RD;
                    end
                end
                ST_DAT_RD: begin
                    if (rem == '0) begin
                        st <= ST_DRAIN;
                    end else if (rsp_valid) begin
                        hold <= rsp_data;
                        st   <= ST_DAT_PUSH;
                    end
                end
                ST_DAT_PUSH: begin
                    if (byte_load) begin
                        rem   <= rem - LEN_W'(byte_ld_cnt);
                        baddr <= baddr + ADDR_W'(WORD_B);
                        st    <= ST_DAT_RD;
                    end
                end
                ST_DRAIN: begin
                    if (byte_empty) st <= ST_WB;
                end
                ST_WB: begin
                    if (rsp_valid) st <= ST_ADV;
                end
                ST_ADV: begin
                    cur_we     <= 1'b1;
                    cur_out    <= nxt;
                    frame_done <= eop;
                    if (dptr == tail_ptr) begin
                        idle_set <= 1'b1;
                        st       <= ST_IDLE;
                    end else begin
                        dptr <= nxt;
                        st   <= ST_RD_STAT;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    sgw_mem_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_we    (cmd_we),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    sgw_byte_emit #(.WORD_W(32)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (byte_load),
        .ld_word   (hold),
        .ld_cnt    (byte_ld_cnt),
        .ld_last   (byte_ld_last),
        .empty     (byte_empty),
        .out_data  (byte_data),
        .out_valid (byte_valid),
        .out_last  (byte_last),
        .out_ready (byte_ready)
    );

    sgw_word_slot #(.WORD_W(32)) u_app (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (app_load),
        .ld_data   (hold),
        .ld_last   (app_idx == APP_LAST_IDX),
        .empty     (app_empty),
        .out_data  (app_data),
        .out_valid (app_valid),
        .out_last  (app_last),
        .out_ready (app_ready)
    );

    // R1: no memory traffic while the walker is parked
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !mem_req);

    // R8: halt and idle never pulse together
    p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_set, idle_set}));

    // R6: packet done only alongside a pointer update
    p_done_with_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> cur_we);

    // R3: a halt never advances the pointer
    p_halt_no_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_set |-> !cur_we);

    // R7: every memory write carries the completion bit
    p_wb_cpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[STAT_CPL_BIT]);
endmodule

// File: tb/sgw_walker_tb.sv
module sgw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, idle_in = 1'b0, start = 1'b0;
    logic [AW-1:0] cur_ptr = '0, tail_ptr = '0;
    logic [AW-1:0] cur_out;
    logic          cur_we, halt_set, idle_set, frame_done;
    logic          mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic [7:0]    byte_data;
    logic          byte_valid, byte_last, byte_ready = 1'b1;
    logic [31:0]   app_data;
    logic          app_valid, app_last, app_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgw_walker #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .idle_in(idle_in), .start(start),
        .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .cur_out(cur_out), .cur_we(cur_we),
        .halt_set(halt_set), .idle_set(idle_set), .frame_done(frame_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
        .app_data(app_data), .app_valid(app_valid), .app_last(app_last), .app_ready(app_ready)
    );

    int n_cmp = 0, n_bad = 0;
    int seed = 0, lat = 0, bp = 0;
    logic [31:0] mem [0:1023];
    logic [15:0] lfsr = 16'hACE1;

    // Captured observations
    logic [7:0]  cap_b [0:63];
    logic        cap_l [0:63];
    logic [31:0] cap_a [0:31];
    logic        cap_al [0:31];
    int n_b, n_a, n_fd, n_halt, n_idle, n_cur, n_acc, n_wr, n_viol;
    logic [31:0] last_cur;
    logic        pv_b, pv_a, pv_m;
    logic [7:0]  pb_d; logic pb_l;
    logic [31:0] pa_d; logic [AW-1:0] pm_a;
    int wait_cnt = 0;

    // Plan of the chain under test
    int t_len [0:3];
    int t_sop [0:3];
    int t_eop [0:3];

    function automatic int dbase(int k); return 32'h100 + 32'h40 * k; endfunction
    function automatic int bbase(int k); return 32'h800 + 32'h40 * k; endfunction
    function automatic logic [7:0] pat(int a); return 8'((a * 13) + (seed * 7) + 5); endfunction

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Memory model: acknowledges after lat idle cycles, data on ack.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1; wait_cnt = 0;
                mem_rdata = mem[mem_addr[11:2]];
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            end else begin
                wait_cnt++;
            end
        end
        if (bp != 0) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            byte_ready = lfsr[0];
            app_ready  = lfsr[3];
        end else begin
            byte_ready = 1'b1; app_ready = 1'b1;
        end
    end

    // Monitor: capture transfers, pulses and stability violations.
    always @(posedge clk) begin
        if (rst_n) begin
            if (byte_valid && byte_ready && n_b < 64) begin cap_b[n_b] = byte_data; cap_l[n_b] = byte_last; n_b++; end
            if (app_valid && app_ready && n_a < 32) begin cap_a[n_a] = app_data; cap_al[n_a] = app_last; n_a++; end
            if (frame_done) n_fd++;
            if (halt_set) n_halt++;
            if (idle_set) n_idle++;
            if (cur_we) begin n_cur++; last_cur = cur_out; end
            if (mem_req && mem_ack) begin n_acc++; if (mem_we) n_wr++; end
            if (pv_b && (!byte_valid || byte_data != pb_d || byte_last != pb_l)) n_viol++;
            if (pv_a && (!app_valid || app_data != pa_d)) n_viol++;
            if (pv_m && (!mem_req || mem_addr != pm_a)) n_viol++;
            pv_b = byte_valid && !byte_ready; pb_d = byte_data; pb_l = byte_last;
            pv_a = app_valid && !app_ready;   pa_d = app_data;
            pv_m = mem_req && !mem_ack;       pm_a = mem_addr;
        end
    end

    task automatic clear_mon();
        n_b = 0; n_a = 0; n_fd = 0; n_halt = 0; n_idle = 0; n_cur = 0;
        n_acc = 0; n_wr = 0; n_viol = 0; last_cur = '0;
        pv_b = 0; pv_a = 0; pv_m = 0;
    endtask

    task automatic fill_mem();
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
    endtask

    task automatic put_desc(int k, int len, int sop, int eop, int done);
        int b;
        b = dbase(k) / 4;
        mem[b+0] = dbase(k + 1);
        mem[b+1] = 32'hA5A5_0000 | k;
        mem[b+2] = bbase(k);
        mem[b+3] = 32'h5A5A_0000 | k;
        mem[b+4] = 32'hDEAD_0001;
        mem[b+5] = 32'hDEAD_0002;
        mem[b+6] = (sop << 27) | (eop << 26) | len | 32'h1080_0000;
        mem[b+7] = done ? 32'h8000_0055 : 32'h0000_0012;
        for (int j = 0; j < 5; j++) mem[b+8+j] = 32'hC000_0000 + k*16 + j;
    endtask

    task automatic walk(int first, int tail);
        int guard;
        clear_mon();
        @(negedge clk);
        cur_ptr = dbase(first); tail_ptr = dbase(tail); run = 1; idle_in = 0; start = 1;
        @(negedge clk);
        start = 0;
        guard = 0;
        while (n_halt + n_idle == 0 && guard < 3000) begin @(negedge clk); guard++; end
        check(guard < 3000, "R8", "walk termination", guard, 0);
        repeat (4) @(negedge clk);
    endtask

    // Compare everything against the planned chain: np descriptors processed.
    task automatic verify(int np, int halted, int ndesc);
        int eb, ea, efd, ex;
        logic [31:0] st;
        eb = 0; ea = 0; efd = 0;
        for (int k = 0; k < np; k++) begin
            for (int i = 0; i < t_len[k]; i++) begin
                ex = (t_eop[k] != 0 && i == t_len[k] - 1) ? 1 : 0;
                if (eb < n_b) begin
                    check(cap_b[eb] == pat(bbase(k) + i), "R4", "byte value", cap_b[eb], pat(bbase(k) + i));
                    check(cap_l[eb] == 1'(ex), "R6", "byte_last", cap_l[eb], ex);
                end
                eb++;
            end
            if (t_sop[k] != 0) begin
                for (int j = 0; j < 5; j++) begin
                    if (ea < n_a) begin
                        check(cap_a[ea] == 32'hC000_0000 + k*16 + j, "R5", "side-band word", cap_a[ea], 32'hC000_0000 + k*16 + j);
                        check(cap_al[ea] == (j == 4), "R5", "app_last", cap_al[ea], (j == 4));
                    end
                    ea++;
                end
            end
            efd += t_eop[k];
            st = mem[dbase(k)/4 + 7];
            check(st == (32'h8000_0000 | t_len[k]), "R7", "written status", st, 32'h8000_0000 | t_len[k]);
        end
        for (int k = np; k < ndesc; k++) begin
            st = mem[dbase(k)/4 + 7];
            check(st[22:0] != 23'(t_len[k]) || st == 32'h8000_0055 || st == 32'h12, "R3", "untouched status", st, 0);
        end
        check(n_b == eb, "R4", "byte count", n_b, eb);
        check(n_a == ea, "R5", "side-band count", n_a, ea);
        check(n_fd == efd, "R6", "frame_done count", n_fd, efd);
        check(n_wr == np, "R7", "write count", n_wr, np);
        check(n_cur == np, "R8", "cur_we count", n_cur, np);
        if (np > 0) check(last_cur == dbase(np), "R8", "cur_out", last_cur, dbase(np));
        check(n_halt == halted, "R3", "halt_set count", n_halt, halted);
        check(n_idle == 1 - halted, "R8", "idle_set count", n_idle, 1 - halted);
        check(n_viol == 0, "R10", "stall stability (also R9)", n_viol, 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        check({cur_we, halt_set, idle_set, frame_done, mem_req, byte_valid, app_valid} == 7'b0,
              "R1", "outputs after reset", {cur_we, halt_set, idle_set, frame_done, mem_req, byte_valid, app_valid}, 0);

        // R1: start ignored without run, or while idle
        seed = 1; fill_mem(); put_desc(0, 4, 1, 1, 0);
        for (int m = 0; m < 2; m++) begin
            clear_mon();
            @(negedge clk);
            cur_ptr = dbase(0); tail_ptr = dbase(0);
            run = (m == 1); idle_in = (m == 1); start = 1;
            @(negedge clk); start = 0;
            repeat (40) @(negedge clk);
            check(n_acc == 0 && n_b == 0 && n_a == 0, "R1", "gated start activity", n_acc + n_b + n_a, 0);
            check(n_cur + n_halt + n_idle + n_fd == 0, "R1", "gated start pulses", n_cur + n_halt + n_idle + n_fd, 0);
        end

        // R4/R6: single-descriptor packets, counts 0..9
        for (int len = 0; len < 10; len++) begin
            seed = len + 3; lat = len % 3; bp = len % 2;
            fill_mem(); put_desc(0, len, 1, 1, 0);
            t_len[0] = len; t_sop[0] = 1; t_eop[0] = 1;
            walk(0, 0);
            verify(1, 0, 1);
        end

        // R2/R4/R5/R6: three-descriptor packets, every count mix 0..4
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 5; c++) begin
                    seed = a*25 + b*5 + c; lat = (a + c) % 3; bp = (b + c) % 2;
                    fill_mem();
                    put_desc(0, a, 1, 0, 0); put_desc(1, b, 0, 0, 0); put_desc(2, c, 0, 1, 0);
                    t_len[0] = a; t_len[1] = b; t_len[2] = c;
                    t_sop[0] = 1; t_sop[1] = 0; t_sop[2] = 0;
                    t_eop[0] = 0; t_eop[1] = 0; t_eop[2] = 1;
                    walk(0, 2);
                    verify(3, 0, 3);
                end

        // R5/R6/R8: two complete packets back to back
        seed = 77; lat = 1; bp = 1; fill_mem();
        put_desc(0, 5, 1, 1, 0); put_desc(1, 3, 1, 1, 0);
        t_len[0] = 5; t_sop[0] = 1; t_eop[0] = 1;
        t_len[1] = 3; t_sop[1] = 1; t_eop[1] = 1;
        walk(0, 1);
        verify(2, 0, 2);

        // R3: completed descriptor mid-chain halts before the tail
        seed = 88; lat = 0; bp = 0; fill_mem();
        put_desc(0, 3, 1, 0, 0); put_desc(1, 6, 0, 1, 1); put_desc(2, 2, 0, 1, 0);
        t_len[0] = 3; t_sop[0] = 1; t_eop[0] = 0;
        t_len[1] = 6; t_len[2] = 2;
        walk(0, 2);
        verify(1, 1, 3);

        // R3: completed first descriptor halts with nothing done
        seed = 91; lat = 2; bp = 1; fill_mem();
        put_desc(0, 7, 1, 1, 1);
        t_len[0] = 7;
        walk(0, 0);
        verify(0, 1, 1);

        // R5/R6: chain with neither flag
        seed = 95; lat = 1; bp = 0; fill_mem();
        put_desc(0, 2, 0, 0, 0); put_desc(1, 5, 0, 0, 0);
        t_len[0] = 2; t_sop[0] = 0; t_eop[0] = 0;
        t_len[1] = 5; t_sop[1] = 0; t_eop[1] = 0;
        walk(0, 1);
        verify(2, 0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule